// File: doc/BRIEF.md
# Power Domain Request Sequencer

This block carries out one power-on or power-off request for a single power area of a system controller, with no processor involved. It acts as a simple register-bus master on the controller's register file. A requester gives it the direction, the channel base offset, the channel bit, the interrupt bit and a delay-quirk flag, and pulses start. The sequencer first sets the optional external-request mask. It then arms the area's interrupt source so that the interrupt is enabled but masked, and clears any stale status for it. Next it waits until the controller can accept a request and submits the request. The per-channel error register is checked after every submit, and a refused request is retried. Finally the sequencer waits for the completion status, clears it and releases the external mask.

Poll spacing and the delay quirk count pulses on a tick input, which is normally one pulse per microsecond. When the sequence ends, a one-cycle done pulse is given together with a status code: ok, not-ready, or I/O error. Arbitration between several requesters lies outside this block.

Top module: `pwr_req_seq`

## Requirements
- R1: After reset, done_o is 0, status_o is 2'b00 (ok) and bus_req_o is 0.
- R2: A start pulse while idle latches the command. If EXT_VAL is nonzero, the first access writes EXT_VAL to address EXT_OFFS. A start pulse while a request is running is ignored: it produces no extra accesses and no extra done pulse.
- R3: Arming takes five accesses in this order. Read 0x10, then write back the read value OR (1 << irq bit). Read 0x0C, then write back the read value OR (1 << irq bit). Write (1 << irq bit) to 0x08. All five come before the first ready poll.
- R4: The ready poll reads address 0x00 and tests bit 1 for power-on or bit 0 for power-off. At least one tick separates two polls. After POLL_LIMIT failed reads, status becomes 2'b01 (not-ready). In that case there is no submit and no completion poll, and the exit path still runs.
- R5: The submit writes (1 << channel bit) to channel base + 0x0C for power-on, or to channel base + 0x04 for power-off.
- R6: For a power-off with the delay flag set, the submit waits for a tick after the successful ready poll. For any other request, the submit is the very next access.
- R7: Each submit is followed by a read of channel base + 0x14. If the channel bit is set, the sequencer waits a tick and then polls for ready and submits again. After RETRY_LIMIT refused attempts, status becomes 2'b10 (I/O error) and the final interrupt clear is skipped.
- R8: Once a submit is accepted, the sequencer reads 0x04 until the irq bit is set, for at most POLL_LIMIT reads with a tick between reads. A timeout gives 2'b10. The sequencer writes (1 << irq bit) to 0x08 after either outcome.
- R9: If EXT_VAL is nonzero, every exit path ends with a write of 0 to EXT_OFFS, and this is the last access of the request.
- R10: done_o is high for exactly one cycle, in the cycle after the last access completes. status_o holds its value until the next accepted start.
- R11: bus_req_o stays high, with address, write data and write enable unchanged, until bus_ack_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing pulse, one per poll interval |
| start_i | input | 1 | Start pulse for a request |
| cmd_on_i | input | 1 | 1 = power-on, 0 = power-off |
| cmd_chan_offs_i | input | AW | Channel register block base |
| cmd_chan_bit_i | input | $clog2(DW) | Channel bit index |
| cmd_irq_bit_i | input | $clog2(DW) | Interrupt bit index |
| cmd_off_dly_i | input | 1 | Delay-quirk flag for power-off |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 ok, 01 not-ready, 10 I/O error |
| bus_req_o | output | 1 | Access strobe |
| bus_we_o | output | 1 | 1 = write |
| bus_addr_o | output | AW | Access address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with ack |
| bus_ack_i | input | 1 | Access ready |

## Verification
The bench drives a ready register that shows only the wrong direction's bit. A sequencer that tests the wrong bit would submit instead of reporting not-ready. It refuses the request twice and then accepts it, and it also refuses it forever. These cases catch a retry loop that skips the ready re-poll, miscounts its limit, or performs the final interrupt clear on the error exit. It withholds the completion bit, which exposes a missing clear after a timeout. It compares power-off submit gaps with and without the delay flag, and a power-on with the flag set, which shows a quirk applied to the wrong requests. A start pulse mid-request and a slow-acking bus catch a sequencer that restarts or a strobe that drops its address before the handshake.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  // common register block
  localparam int unsigned OFS_STAT     = 'h00;
  localparam int unsigned OFS_IRQ_STAT = 'h04;
  localparam int unsigned OFS_IRQ_CLR  = 'h08;
  localparam int unsigned OFS_IRQ_EN   = 'h0C;
  localparam int unsigned OFS_IRQ_MASK = 'h10;

  // per-channel block
  localparam int unsigned CH_OFF = 'h04;
  localparam int unsigned CH_ON  = 'h0C;
  localparam int unsigned CH_ERR = 'h14;

  typedef enum logic [1:0] {
    ST_OK        = 2'b00,
    ST_NOT_READY = 2'b01,
    ST_IO_ERR    = 2'b10
  } pwr_stat_e;

  typedef enum logic [4:0] {
    S_IDLE, S_EXT_SET, S_IMR_RD, S_IMR_WR, S_IER_RD, S_IER_WR, S_ISC_CLR,
    S_RDY_RD, S_RDY_WAIT, S_DLY_WAIT, S_SUBMIT, S_ERR_RD, S_RETRY_WAIT,
    S_IRQ_RD, S_IRQ_WAIT, S_FIN_CLR, S_EXT_CLR
  } seq_state_e;

endpackage

// File: rtl/pwr_seq_bus.sv
`timescale 1ns/1ps
module pwr_seq_bus #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          bus_ack_i,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_we_o,
  output logic          cpl_o,
  output logic          busy_o
);

  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (req_q && bus_ack_i) begin
      req_q <= 1'b0;
    end else if (issue_i && !req_q) begin
      req_q   <= 1'b1;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
    end
  end

  assign bus_req_o   = req_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_we_o    = we_q;
  assign cpl_o       = req_q & bus_ack_i;
  assign busy_o      = req_q;

  // R11: strobe and payload held until the handshake
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_wdata_o) && $stable(bus_we_o)));

endmodule

// File: rtl/pwr_seq_cnt.sv
`timescale 1ns/1ps
module pwr_seq_cnt #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == W'(LIMIT - 1));

  // R4, R7, R8: attempt count never passes its limit
  a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LIMIT - 1));

endmodule

// File: rtl/pwr_req_seq.sv
`timescale 1ns/1ps
module pwr_req_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 32,
  parameter int unsigned POLL_LIMIT  = 1000,
  parameter int unsigned RETRY_LIMIT = 1000,
  parameter int unsigned EXT_OFFS    = 'h180,
  parameter logic [DW-1:0] EXT_VAL   = '0,
  localparam int unsigned IW         = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          cmd_on_i,
  input  logic [AW-1:0] cmd_chan_offs_i,
  input  logic [IW-1:0] cmd_chan_bit_i,
  input  logic [IW-1:0] cmd_irq_bit_i,
  input  logic          cmd_off_dly_i,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i
);

  localparam bit EXT_ACTIVE = (EXT_VAL != '0);
  localparam logic [AW-1:0] EXT_ADDR = AW'(EXT_OFFS);

  seq_state_e state_q, state_d, exit_st;
  logic          on_q, dly_q;
  logic [AW-1:0] chan_q;
  logic [IW-1:0] cbit_q, ibit_q;
  logic [DW-1:0] tmp_q;
  pwr_stat_e     stat_q, stat_new;
  logic          done_q, fin, stat_upd, tmp_ld;
  logic          poll_inc, poll_clr, poll_last;
  logic          rtry_inc, rtry_clr, rtry_last;

  logic          bus_stage, issue, cpl, bus_busy, acc_we;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata, irq_mask, chan_mask;
  logic          rdy_hit, chan_hit, irq_hit;

  assign irq_mask  = DW'(1) << ibit_q;
  assign chan_mask = DW'(1) << cbit_q;
  assign rdy_hit   = on_q ? bus_rdata_i[1] : bus_rdata_i[0];
  assign chan_hit  = bus_rdata_i[cbit_q];
  assign irq_hit   = bus_rdata_i[ibit_q];
  assign exit_st   = EXT_ACTIVE ? S_EXT_CLR : S_IDLE;

  // access selected by the current stage
  always_comb begin
    bus_stage = 1'b1;
    acc_we    = 1'b0;
    acc_addr  = '0;
    acc_wdata = '0;
    unique case (state_q)
      S_EXT_SET: begin acc_we = 1'b1; acc_addr = EXT_ADDR; acc_wdata = EXT_VAL; end
      S_IMR_RD:  acc_addr = AW'(OFS_IRQ_MASK);
      S_IMR_WR:  begin acc_we = 1'b1; acc_addr = AW'(OFS_IRQ_MASK); acc_wdata = tmp_q | irq_mask; end
      S_IER_RD:  acc_addr = AW'(OFS_IRQ_EN);
      S_IER_WR:  begin acc_we = 1'b1; acc_addr = AW'(OFS_IRQ_EN); acc_wdata = tmp_q | irq_mask; end
      S_ISC_CLR, S_FIN_CLR: begin acc_we = 1'b1; acc_addr = AW'(OFS_IRQ_CLR); acc_wdata = irq_mask; end
      S_RDY_RD:  acc_addr = AW'(OFS_STAT);
      S_SUBMIT:  begin
        acc_we    = 1'b1;
        acc_addr  = chan_q + (on_q ? AW'(CH_ON) : AW'(CH_OFF));
        acc_wdata = chan_mask;
      end
      S_ERR_RD:  acc_addr = chan_q + AW'(CH_ERR);
      S_IRQ_RD:  acc_addr = AW'(OFS_IRQ_STAT);
      S_EXT_CLR: begin acc_we = 1'b1; acc_addr = EXT_ADDR; end
      default:   bus_stage = 1'b0;
    endcase
  end

  assign issue = bus_stage & ~bus_busy;

  pwr_seq_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .addr_i      (acc_addr),
    .wdata_i     (acc_wdata),
    .we_i        (acc_we),
    .bus_ack_i   (bus_ack_i),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_we_o    (bus_we_o),
    .cpl_o       (cpl),
    .busy_o      (bus_busy)
  );

  pwr_seq_cnt #(.LIMIT(POLL_LIMIT)) u_poll_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  pwr_seq_cnt #(.LIMIT(RETRY_LIMIT)) u_rtry_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rtry_clr),
    .inc_i  (rtry_inc),
    .last_o (rtry_last)
  );

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    poll_inc = 1'b0;
    poll_clr = (state_q == S_IDLE);
    rtry_inc = 1'b0;
    rtry_clr = (state_q == S_IDLE);
    stat_upd = 1'b0;
    stat_new = ST_OK;
    tmp_ld   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        stat_upd = 1'b1;
        state_d  = EXT_ACTIVE ? S_EXT_SET : S_IMR_RD;
      end
      S_EXT_SET: if (cpl) state_d = S_IMR_RD;
      S_IMR_RD:  if (cpl) begin tmp_ld = 1'b1; state_d = S_IMR_WR; end
      S_IMR_WR:  if (cpl) state_d = S_IER_RD;
      S_IER_RD:  if (cpl) begin tmp_ld = 1'b1; state_d = S_IER_WR; end
      S_IER_WR:  if (cpl) state_d = S_ISC_CLR;
      S_ISC_CLR: if (cpl) state_d = S_RDY_RD;
      S_RDY_RD: if (cpl) begin
        if (rdy_hit) begin
          poll_clr = 1'b1;
          state_d  = (!on_q && dly_q) ? S_DLY_WAIT : S_SUBMIT;
        end else if (poll_last) begin
          poll_clr = 1'b1;
          stat_upd = 1'b1;
          stat_new = ST_NOT_READY;
          state_d  = exit_st;
          fin      = ~EXT_ACTIVE;
        end else begin
          poll_inc = 1'b1;
          state_d  = S_RDY_WAIT;
        end
      end
      S_RDY_WAIT:   if (tick_i) state_d = S_RDY_RD;
      S_DLY_WAIT:   if (tick_i) state_d = S_SUBMIT;
      S_SUBMIT:     if (cpl) state_d = S_ERR_RD;
      S_ERR_RD: if (cpl) begin
        if (!chan_hit) begin
          rtry_clr = 1'b1;
          state_d  = S_IRQ_RD;
        end else if (rtry_last) begin
          rtry_clr = 1'b1;
          stat_upd = 1'b1;
          stat_new = ST_IO_ERR;
          state_d  = exit_st;
          fin      = ~EXT_ACTIVE;
        end else begin
          rtry_inc = 1'b1;
          state_d  = S_RETRY_WAIT;
        end
      end
      S_RETRY_WAIT: if (tick_i) state_d = S_RDY_RD;
      S_IRQ_RD: if (cpl) begin
        if (irq_hit) begin
          poll_clr = 1'b1;
          state_d  = S_FIN_CLR;
        end else if (poll_last) begin
          poll_clr = 1'b1;
          stat_upd = 1'b1;
          stat_new = ST_IO_ERR;
          state_d  = S_FIN_CLR;
        end else begin
          poll_inc = 1'b1;
          state_d  = S_IRQ_WAIT;
        end
      end
      S_IRQ_WAIT: if (tick_i) state_d = S_IRQ_RD;
      S_FIN_CLR: if (cpl) begin
        state_d = exit_st;
        fin     = ~EXT_ACTIVE;
      end
      S_EXT_CLR: if (cpl) begin
        state_d = S_IDLE;
        fin     = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      on_q    <= 1'b0;
      dly_q   <= 1'b0;
      chan_q  <= '0;
      cbit_q  <= '0;
      ibit_q  <= '0;
      tmp_q   <= '0;
      stat_q  <= ST_OK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (state_q == S_IDLE && start_i) begin
        on_q   <= cmd_on_i;
        dly_q  <= cmd_off_dly_i;
        chan_q <= cmd_chan_offs_i;
        cbit_q <= cmd_chan_bit_i;
        ibit_q <= cmd_irq_bit_i;
      end
      if (tmp_ld)   tmp_q  <= bus_rdata_i;
      if (stat_upd) stat_q <= stat_new;
    end
  end

  assign done_o   = done_q;
  assign status_o = stat_q;

  // R10: done is a single-cycle pulse with a legal code
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_stat_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'b11));
  // R2: no bus activity while idle
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !bus_req_o);

  generate
    if (EXT_ACTIVE) begin : g_ext_chk
      // R9: the external mask release is the final handshake
      a_r9_ext_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(bus_req_o && bus_ack_i && bus_we_o &&
                         bus_addr_o == EXT_ADDR && bus_wdata_o == '0));
    end
  endgenerate

endmodule

// File: tb/tb_pwr_req_seq.sv
`timescale 1ns/1ps
module tb_pwr_req_seq;

  localparam int P  = 6;
  localparam int RT = 3;
  localparam logic [15:0] EXT_O = 16'h0180;
  localparam logic [31:0] EXT_V = 32'h0000_0005;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        tick_i = 1'b0, start_i = 1'b0, on_i = 1'b0, dly_i = 1'b0;
  logic [15:0] chan_i = '0;
  logic [4:0]  cbit_i = '0, ibit_i = '0;
  logic        done_o, bus_req_o, bus_we_o;
  logic [1:0]  status_o;
  logic [15:0] bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] rdata_q = '0;
  logic        ack_q = 1'b0;

  pwr_req_seq #(.AW(16), .DW(32), .POLL_LIMIT(P), .RETRY_LIMIT(RT),
                .EXT_OFFS(EXT_O), .EXT_VAL(EXT_V)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .start_i(start_i),
    .cmd_on_i(on_i), .cmd_chan_offs_i(chan_i), .cmd_chan_bit_i(cbit_i),
    .cmd_irq_bit_i(ibit_i), .cmd_off_dly_i(dly_i), .done_o(done_o),
    .status_o(status_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(rdata_q), .bus_ack_i(ack_q));

  int errs = 0, checks = 0;

  // register model
  int sr_fail, err_fail, isr_fail, slv_lat = 0, lat_cnt = 0, tick_div = 4, div = 0;
  logic [31:0] sr_val, imr, ier;
  logic [15:0] m_chan;
  int m_cb, m_ib;
  int log_n = 0, cyc = 0, tk = 0, done_cnt = 0, stab_bad = 0;
  logic        log_we [64];
  logic [15:0] log_a  [64];
  logic [31:0] log_d  [64];
  int          log_cyc[64];
  int          log_tk [64];
  logic        pw = 1'b0;
  logic [15:0] pa;
  logic [31:0] pd;

  function automatic logic [31:0] model_rd(input logic [15:0] a);
    if (a == 16'h0000) begin
      if (sr_fail > 0) begin sr_fail--; return 32'h0; end
      return sr_val;
    end
    if (a == 16'h0010) return imr;
    if (a == 16'h000C) return ier;
    if (a == 16'h0004) begin
      if (isr_fail > 0) begin isr_fail--; return 32'h0; end
      return 32'h1 << m_ib;
    end
    if (a == m_chan + 16'h0014) begin
      if (err_fail > 0) begin err_fail--; return 32'h1 << m_cb; end
      return ~(32'h1 << m_cb);
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (pw && !(bus_req_o && bus_addr_o == pa && bus_wdata_o == pd)) stab_bad++;
    pw = bus_req_o && !ack_q;
    pa = bus_addr_o;
    pd = bus_wdata_o;
    if (bus_req_o && ack_q) begin
      if (log_n < 64) begin
        log_we[log_n] = bus_we_o; log_a[log_n] = bus_addr_o; log_d[log_n] = bus_wdata_o;
        log_cyc[log_n] = cyc; log_tk[log_n] = tk;
      end
      log_n++;
      if (bus_we_o && bus_addr_o == 16'h0010) imr = bus_wdata_o;
      if (bus_we_o && bus_addr_o == 16'h000C) ier = bus_wdata_o;
      ack_q <= 1'b0;
    end else if (bus_req_o) begin
      if (lat_cnt >= slv_lat) begin
        ack_q   <= 1'b1;
        rdata_q <= bus_we_o ? 32'h0 : model_rd(bus_addr_o);
        lat_cnt = 0;
      end else lat_cnt++;
    end else ack_q <= 1'b0;
    if (tick_i) tk++;
    if (done_o) done_cnt++;
    tick_i <= (div == tick_div - 1);
    div = (div >= tick_div - 1) ? 0 : div + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_acc(input int i, input bit we, input logic [15:0] a,
                         input logic [31:0] wd, input string tag);
    bit ok;
    checks++;
    ok = (i < log_n) && (log_we[i] == we) && (log_a[i] == a) && (!we || log_d[i] == wd);
    if (!ok) begin
      errs++;
      if (i < log_n)
        $display("FAIL %s access %0d: actual we=%0d addr=%h data=%h expected we=%0d addr=%h data=%h",
                 tag, i, log_we[i], log_a[i], log_d[i], we, a, wd);
      else
        $display("FAIL %s access %0d: actual missing (n=%0d) expected we=%0d addr=%h", tag, i, log_n, we, a);
    end
  endtask

  task automatic run_req(input bit on, input logic [15:0] ch, input int cb, input int ib,
                         input bit dl, output logic [1:0] st);
    int n;
    m_chan = ch; m_cb = cb; m_ib = ib;
    imr = 32'h0000_0100; ier = 32'h0000_0030;
    log_n = 0;
    @(negedge clk);
    on_i = on; chan_i = ch; cbit_i = 5'(cb); ibit_i = 5'(ib); dly_i = dl;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    chk(done_o, "R10 done reached (watchdog)", 32'(done_o), 32'h1);
    st = status_o;
    @(negedge clk);
    chk(!done_o, "R10 done one cycle", 32'(done_o), 32'h0);
  endtask

  task automatic chk_setup(input int ib, input string tag);
    chk_acc(0, 1, EXT_O, EXT_V, {tag, " R2 ext mask set"});
    chk_acc(1, 0, 16'h0010, 0, {tag, " R3 mask rd"});
    chk_acc(2, 1, 16'h0010, 32'h100 | (32'h1 << ib), {tag, " R3 mask wr"});
    chk_acc(3, 0, 16'h000C, 0, {tag, " R3 enable rd"});
    chk_acc(4, 1, 16'h000C, 32'h30 | (32'h1 << ib), {tag, " R3 enable wr"});
    chk_acc(5, 1, 16'h0008, 32'h1 << ib, {tag, " R3 clear"});
  endtask

  task automatic set_model(input logic [31:0] srv, input int sf, input int ef, input int isf);
    sr_val = srv; sr_fail = sf; err_fail = ef; isr_fail = isf;
  endtask

  task automatic t_reset;
    chk(done_o == 0 && status_o == 2'b00 && bus_req_o == 0, "R1 reset state",
        {29'h0, done_o, status_o}, 32'h0);
  endtask

  task automatic t_on_basic;
    logic [1:0] st;
    set_model(32'h2, 0, 0, 2);
    run_req(1, 16'h0040, 3, 7, 1, st);
    chk_setup(7, "on");
    chk_acc(6, 0, 16'h0000, 0, "on R4 ready rd");
    chk_acc(7, 1, 16'h004C, 32'h8, "on R5 submit");
    chk(log_cyc[7] - log_cyc[6] == 3, "on R6 flag ignored for on", 32'(log_cyc[7] - log_cyc[6]), 3);
    chk_acc(8, 0, 16'h0054, 0, "on R7 err rd");
    for (int i = 9; i < 12; i++) chk_acc(i, 0, 16'h0004, 0, "on R8 irq poll");
    chk_acc(12, 1, 16'h0008, 32'h80, "on R8 final clear");
    chk_acc(13, 1, EXT_O, 0, "on R9 ext release");
    chk(log_n == 14, "on access count", 32'(log_n), 14);
    chk(st == 2'b00, "on R10 status ok", 32'(st), 0);
  endtask

  task automatic t_off_plain;
    logic [1:0] st;
    set_model(32'h1, 0, 0, 0);
    run_req(0, 16'h0080, 0, 2, 0, st);
    chk_acc(7, 1, 16'h0084, 32'h1, "off R5 submit");
    chk(log_cyc[7] - log_cyc[6] == 3, "off R6 no delay", 32'(log_cyc[7] - log_cyc[6]), 3);
    chk(st == 2'b00, "off status ok", 32'(st), 0);
  endtask

  task automatic t_off_quirk;
    logic [1:0] st;
    tick_div = 20;
    set_model(32'h1, 0, 0, 0);
    run_req(0, 16'h0080, 0, 2, 1, st);
    tick_div = 4;
    chk_acc(7, 1, 16'h0084, 32'h1, "quirk R5 submit");
    chk(log_tk[7] > log_tk[6], "quirk R6 tick before submit", 32'(log_tk[7] - log_tk[6]), 1);
    chk(log_cyc[7] - log_cyc[6] > 3, "quirk R6 gap", 32'(log_cyc[7] - log_cyc[6]), 4);
  endtask

  task automatic t_not_ready;
    logic [1:0] st;
    bit sp;
    set_model(32'h1, 0, 0, 0);
    run_req(1, 16'h0040, 3, 7, 0, st);
    chk_setup(7, "nr");
    for (int i = 6; i < 6 + P; i++) chk_acc(i, 0, 16'h0000, 0, "nr R4 wrong bit ignored");
    sp = 1'b1;
    for (int i = 7; i < 6 + P; i++) if (log_tk[i] <= log_tk[i-1]) sp = 1'b0;
    chk(sp, "nr R4 polls tick spaced", 32'(sp), 1);
    chk_acc(6 + P, 1, EXT_O, 0, "nr R9 ext release");
    chk(log_n == 7 + P, "nr R4 no submit", 32'(log_n), 7 + P);
    chk(st == 2'b01, "nr R4 status", 32'(st), 1);
    repeat (20) @(negedge clk);
    chk(status_o == 2'b01, "nr R10 status held", 32'(status_o), 1);
  endtask

  task automatic t_retry_ok;
    logic [1:0] st;
    set_model(32'h2, 0, 2, 0);
    run_req(1, 16'h0040, 5, 9, 0, st);
    for (int k = 0; k < 3; k++) begin
      chk_acc(6 + 3*k, 0, 16'h0000, 0, "retry R7 re-poll");
      chk_acc(7 + 3*k, 1, 16'h004C, 32'h20, "retry R7 resubmit");
      chk_acc(8 + 3*k, 0, 16'h0054, 0, "retry R7 err rd");
    end
    chk_acc(15, 0, 16'h0004, 0, "retry R8 irq rd");
    chk_acc(16, 1, 16'h0008, 32'h200, "retry R8 clear");
    chk(log_n == 18, "retry count", 32'(log_n), 18);
    chk(st == 2'b00, "retry R7 status ok", 32'(st), 0);
  endtask

  task automatic t_retry_fail;
    logic [1:0] st;
    set_model(32'h2, 0, 99, 0);
    run_req(1, 16'h0040, 5, 9, 0, st);
    chk_acc(14, 0, 16'h0054, 0, "rfail R7 last err rd");
    chk_acc(15, 1, EXT_O, 0, "rfail R7 R9 no final clear");
    chk(log_n == 16, "rfail R7 count", 32'(log_n), 16);
    chk(st == 2'b10, "rfail R7 status", 32'(st), 2);
  endtask

  task automatic t_irq_timeout;
    logic [1:0] st;
    set_model(32'h2, 0, 0, 99);
    run_req(1, 16'h0040, 3, 4, 0, st);
    for (int i = 9; i < 9 + P; i++) chk_acc(i, 0, 16'h0004, 0, "itmo R8 poll");
    chk_acc(9 + P, 1, 16'h0008, 32'h10, "itmo R8 clear after timeout");
    chk_acc(10 + P, 1, EXT_O, 0, "itmo R9 ext release");
    chk(log_n == 11 + P, "itmo count", 32'(log_n), 11 + P);
    chk(st == 2'b10, "itmo R8 status", 32'(st), 2);
  endtask

  task automatic t_busy_start;
    logic [1:0] st;
    int d0, n0;
    d0 = done_cnt;
    set_model(32'h2, 0, 0, 0);
    fork
      run_req(1, 16'h0040, 3, 7, 0, st);
      begin
        repeat (10) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    join
    n0 = log_n;
    repeat (30) @(negedge clk);
    chk(log_n == 12 && n0 == 12, "busy R2 start ignored", 32'(log_n), 12);
    chk_acc(7, 1, 16'h004C, 32'h8, "busy R2 command kept");
    chk(done_cnt - d0 == 1, "busy R2 one done", 32'(done_cnt - d0), 1);
  endtask

  task automatic t_slow_bus;
    logic [1:0] st;
    stab_bad = 0;
    slv_lat = 3;
    set_model(32'h2, 0, 0, 0);
    run_req(1, 16'h0040, 3, 7, 0, st);
    slv_lat = 0;
    chk(stab_bad == 0, "slow R11 request held", 32'(stab_bad), 0);
    chk_setup(7, "slow");
    chk(log_n == 12 && st == 2'b00, "slow R11 sequence", 32'(log_n), 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_on_basic;
    t_off_plain;
    t_off_quirk;
    t_not_ready;
    t_retry_ok;
    t_retry_fail;
    t_irq_timeout;
    t_busy_start;
    t_slow_bus;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule